// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a two-channel serial audio stream made of three signals: a bit clock, a word-select level and a serial data line. It recovers one left and one right sample per frame. All three signals are brought into the system clock domain by synchronizer flops. Bit-clock rising edges are then found by edge detection, so the system clock must run at least four times as fast as the bit clock. Each frame is 64 bit clocks long, split into two halves of 32 bits, one for each word-select level.

A 3-bit format selector chooses one of seven framings. The first family is right-justified: the sample ends on the last bit before the word-select change, and a sliding shift register holds the most recent bits. The second family is left-justified with a one-bit gap: a counter restarts at each word-select change and picks out the bits that follow the gap. The two families differ in which word-select level carries the left channel and in which word-select edge ends the frame.

At the end of each frame the left and right samples are presented together, MSB-aligned in 24-bit words, with a one-cycle strobe. A new format applies only from a frame boundary onward. The frame after reset and the frame after a format change are not presented.

Top module: `serial_audio_rx`

## Requirements
- R1: Serial data is taken at the rising edge of the bit clock. A change of the data line while the bit clock is high does not alter the received sample.
- R2: Format codes: 0 = right-justified 16 bit, 1 = right-justified 20 bit, 2 = right-justified 24 bit, 6 = right-justified 18 bit, 7 = same as code 2, 3 = left-justified 16 bit, 4 = left-justified 20 bit, 5 = left-justified 24 bit.
- R3: In right-justified formats, word-select high is the left channel and low is the right channel. The sample is the last N bits received before the word-select change, MSB first. Earlier bits of the half are ignored.
- R4: In right-justified formats, the frame ends at a rising edge of word-select. The pair is committed there: the left sample comes from the preceding high half and the right sample from the low half that just ended.
- R5: In left-justified formats, word-select low is the left channel and high is the right channel. The first bit after each word-select change is ignored, the next N bits are the sample MSB first, and any later bits are ignored.
- R6: In left-justified formats, the frame ends at a falling edge of word-select, where the pair is committed.
- R7: A sample of N bits is placed in bits 23 down to 24-N of the output word, and the lower 24-N bits are zero.
- R8: Each committed pair comes with a strobe exactly one system clock long. The strobe and the new data appear at the third rising system clock edge, counting from the first edge that sees the bit clock high at the commit point.
- R9: The format input is sampled only at a frame boundary. At that boundary the pair of the frame that ended is still presented under the old format, and the next frame is discarded. After reset, the first frame boundary produces no strobe.
- R10: After reset the strobe is low and both sample outputs are zero.
- R11: Between strobes both sample outputs hold their last committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 3 | Format code, applied at the next frame boundary |
| bit_clk | input | 1 | Serial bit clock, asynchronous to clk |
| word_sel | input | 1 | Word-select (channel) level |
| ser_data | input | 1 | Serial data line |
| smp_left | output | 24 | Left sample, MSB-aligned |
| smp_right | output | 24 | Right sample, MSB-aligned |
| smp_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
Frames are sent in every format code, including the reserved code, with random filler in every bit slot the format does not use. This separates right-justified extraction (the last bits before the change) from left-justified extraction (the bits after the gap). Some frames invert the data line halfway through the bit clock's high phase, which exposes sampling on the wrong edge or after the wrong synchronizer delay. Format changes within one family and across the two families show whether the frame boundary follows the old format's word-select edge and whether the frame after the change is dropped. Comparing the strobe cycle by cycle checks the fixed latency and the holding of the outputs between strobes.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam int MAX_BITS = 24;

   typedef enum logic [2:0] {
      FMT_RJ16  = 3'd0,
      FMT_RJ20  = 3'd1,
      FMT_RJ24  = 3'd2,
      FMT_LJ16  = 3'd3,
      FMT_LJ20  = 3'd4,
      FMT_LJ24  = 3'd5,
      FMT_RJ18  = 3'd6,
      FMT_RJ24B = 3'd7
   } fmt_e;

   // sample length carried by a format
   function automatic int unsigned fmt_bits(fmt_e f);
      case (f)
         FMT_RJ16, FMT_LJ16: return 16;
         FMT_RJ20, FMT_LJ20: return 20;
         FMT_RJ18:           return 18;
         default:            return 24;
      endcase
   endfunction

   // left-justified (one-bit gap) family
   function automatic logic fmt_lj(fmt_e f);
      return (f == FMT_LJ16) || (f == FMT_LJ20) || (f == FMT_LJ24);
   endfunction

endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_clk_i,
   input  logic word_sel_i,
   input  logic ser_data_i,
   output logic bit_rise_o,
   output logic ws_o,
   output logic sd_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sar_sync_edge: STAGES must be at least 2");
   end

   // bit 0 = bit clock, bit 1 = word select, bit 2 = data
   logic [2:0] stg_q [STAGES];
   logic       bclk_last_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= '0;
            else        stg_q[0] <= {ser_data_i, word_sel_i, bit_clk_i};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_last_q <= 1'b0;
      else        bclk_last_q <= stg_q[STAGES-1][0];
   end

   assign bit_rise_o = stg_q[STAGES-1][0] & ~bclk_last_q;
   assign ws_o       = stg_q[STAGES-1][1];
   assign sd_o       = stg_q[STAGES-1][2];

endmodule

// File: rtl/sar_slot_capture.sv
module sar_slot_capture
   import sar_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_rise,
   input  logic                ws,
   input  logic                sd,
   input  fmt_e                act_mode,
   output logic                edge_o,
   output logic                ws_was_o,
   output logic [SAMPLE_W-1:0] word_o
);

   localparam int             CNT_W    = $clog2(MAX_BITS + 2);
   localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(MAX_BITS + 1);

   if (SAMPLE_W < MAX_BITS) begin : g_bad_width
      $error("sar_slot_capture: SAMPLE_W below longest sample");
   end

   logic                seen_q;
   logic                ws_q;
   logic [MAX_BITS-1:0] shift_q;
   logic [SAMPLE_W-1:0] lj_q;
   logic [CNT_W-1:0]    idx_q;

   int unsigned         nbits;
   logic                lj;
   logic [SAMPLE_W-1:0] rj_word;
   logic [SAMPLE_W-1:0] lj_bit;

   always_comb begin
      nbits   = fmt_bits(act_mode);
      lj      = fmt_lj(act_mode);
      rj_word = SAMPLE_W'(shift_q) << (SAMPLE_W - nbits);
      lj_bit  = {sd, {(SAMPLE_W-1){1'b0}}} >> (idx_q - 1'b1);
   end

   assign edge_o   = bit_rise & seen_q & (ws != ws_q);
   assign ws_was_o = ws_q;
   assign word_o   = lj ? lj_q : rj_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b0;
         ws_q    <= 1'b0;
         shift_q <= '0;
         lj_q    <= '0;
         idx_q   <= CNT_IDLE;
      end else if (bit_rise) begin
         seen_q  <= 1'b1;
         ws_q    <= ws;
         shift_q <= {shift_q[MAX_BITS-2:0], sd};
         if (edge_o) begin
            // this bit is the gap slot of the new half
            idx_q <= CNT_W'(1);
            lj_q  <= '0;
         end else begin
            if ((idx_q != '0) && (32'(idx_q) <= nbits))
               lj_q <= lj_q | lj_bit;
            if (idx_q != CNT_IDLE)
               idx_q <= idx_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sar_pair_commit.sv
module sar_pair_commit
   import sar_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt_sel,
   input  logic                edge_i,
   input  logic                ws_was_i,
   input  logic [SAMPLE_W-1:0] word_i,
   output fmt_e                act_mode_o,
   output logic                valid_o,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o
);

   fmt_e                act_q;
   logic                drop_q;
   logic [SAMPLE_W-1:0] hold_q;
   logic                ending_left;
   logic                boundary;

   // right-justified: high half is left; left-justified: low half is left
   assign ending_left = ws_was_i ^ fmt_lj(act_q);
   assign boundary    = edge_i & ~ending_left;
   assign act_mode_o  = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= FMT_RJ16;
         drop_q  <= 1'b1;
         hold_q  <= '0;
         valid_o <= 1'b0;
         left_o  <= '0;
         right_o <= '0;
      end else begin
         valid_o <= 1'b0;
         if (edge_i && ending_left)
            hold_q <= word_i;
         if (boundary) begin
            if (!drop_q) begin
               left_o  <= hold_q;
               right_o <= word_i;
               valid_o <= 1'b1;
            end
            drop_q <= (fmt_e'(fmt_sel) != act_q);
            act_q  <= fmt_e'(fmt_sel);
         end
      end
   end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt_sel,
   input  logic                bit_clk,
   input  logic                word_sel,
   input  logic                ser_data,
   output logic [SAMPLE_W-1:0] smp_left,
   output logic [SAMPLE_W-1:0] smp_right,
   output logic                smp_valid
);

   logic                bit_rise;
   logic                ws_s;
   logic                sd_s;
   logic                slot_edge;
   logic                ws_was;
   logic [SAMPLE_W-1:0] slot_word;
   fmt_e                act_mode;

   sar_sync_edge #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_clk_i (bit_clk),
      .word_sel_i(word_sel),
      .ser_data_i(ser_data),
      .bit_rise_o(bit_rise),
      .ws_o      (ws_s),
      .sd_o      (sd_s)
   );

   sar_slot_capture #(
      .SAMPLE_W(SAMPLE_W)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_rise(bit_rise),
      .ws      (ws_s),
      .sd      (sd_s),
      .act_mode(act_mode),
      .edge_o  (slot_edge),
      .ws_was_o(ws_was),
      .word_o  (slot_word)
   );

   sar_pair_commit #(
      .SAMPLE_W(SAMPLE_W)
   ) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt_sel   (fmt_sel),
      .edge_i    (slot_edge),
      .ws_was_i  (ws_was),
      .word_i    (slot_word),
      .act_mode_o(act_mode),
      .valid_o   (smp_valid),
      .left_o    (smp_left),
      .right_o   (smp_right)
   );

endmodule

// File: rtl/sar_chk.sv
module sar_chk
   import sar_pkg::*;
#(
   parameter int W = 24
) (
   input logic         clk,
   input logic         rst_n,
   input logic         valid,
   input logic [W-1:0] left,
   input logic [W-1:0] right,
   input fmt_e         act_mode,
   input logic         bit_rise
);

   function automatic logic [W-1:0] low_mask(fmt_e f);
      return (W'(1) << (W - fmt_bits(f))) - W'(1);
   endfunction

   // R8
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R1
   valid_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(bit_rise));

   // R11
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ($stable(left) && $stable(right)));

   // R7
   lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (((left | right) & low_mask($past(act_mode))) == '0));

   // R10
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!valid && left == '0 && right == '0));

endmodule

bind serial_audio_rx sar_chk #(.W(SAMPLE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .valid   (smp_valid),
   .left    (smp_left),
   .right   (smp_right),
   .act_mode(act_mode),
   .bit_rise(bit_rise)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  fmt_sel = 3'd0;
   logic        bit_clk = 1'b0;
   logic        word_sel = 1'b0;
   logic        ser_data = 1'b0;
   logic [23:0] smp_left;
   logic [23:0] smp_right;
   logic        smp_valid;

   int n_cmp  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit rst_done = 0;
   bit finished = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   serial_audio_rx dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt_sel  (fmt_sel),
      .bit_clk  (bit_clk),
      .word_sel (word_sel),
      .ser_data (ser_data),
      .smp_left (smp_left),
      .smp_right(smp_right),
      .smp_valid(smp_valid)
   );

   typedef struct {
      int          at;
      logic [23:0] l;
      logic [23:0] r;
      bit          lj;
   } exp_t;

   exp_t        exp_q[$];
   logic        bits_q[$];
   bit          m_seen   = 0;
   logic        m_wsprev = 0;
   int          m_act    = 0;
   bit          m_drop   = 1;
   logic [23:0] m_left   = '0;
   logic [23:0] last_l   = '0;
   logic [23:0] last_r   = '0;
   bit          got_any  = 0;

   // R2: format table, written from the requirement
   function automatic int m_width(int code);
      case (code)
         0, 3: return 16;
         1, 4: return 20;
         6:    return 18;
         default: return 24;
      endcase
   endfunction

   function automatic bit m_lj(int code);
      return (code == 3) || (code == 4) || (code == 5);
   endfunction

   // R3 / R5 / R7: sample extraction from the bits of one half
   function automatic logic [23:0] m_extract(bit lj, int n);
      logic [23:0] v;
      v = '0;
      if (lj) begin
         for (int k = 1; k <= n; k++)
            if (k < bits_q.size() && bits_q[k]) v[24-k] = 1'b1;
      end else begin
         for (int i = 0; i < n; i++) begin
            int p;
            p = bits_q.size() - n + i;
            if (p >= 0 && bits_q[p]) v[23-i] = 1'b1;
         end
      end
      return v;
   endfunction

   // behavioural model, run at each driven bit-clock rise
   task automatic model_rise(input logic ws, input logic sd);
      logic [23:0] w;
      bit          lj;
      bit          ending_left;
      exp_t        e;
      if (m_seen && ws != m_wsprev) begin
         lj = m_lj(m_act);
         w  = m_extract(lj, m_width(m_act));
         ending_left = (m_wsprev != lj);
         if (ending_left) m_left = w;
         else begin
            // R4 / R6: frame end; R9: drop and format pick-up
            if (!m_drop) begin
               e.at = cyc + 3;   // R8 latency
               e.l  = m_left;
               e.r  = w;
               e.lj = lj;
               exp_q.push_back(e);
            end
            m_drop = (int'(fmt_sel) != m_act);
            m_act  = int'(fmt_sel);
         end
         bits_q.delete();
      end
      bits_q.push_back(sd);
      m_seen   = 1;
      m_wsprev = ws;
   endtask

   // R1: glitch flips the data line while the bit clock is high
   task automatic send_bit(input logic ws, input logic sd, input bit glitch);
      @(negedge clk);
      bit_clk  = 1'b0;
      word_sel = ws;
      ser_data = sd;
      repeat (3) @(negedge clk);
      @(negedge clk);
      bit_clk = 1'b1;
      model_rise(ws, sd);
      repeat (2) @(negedge clk);
      if (glitch) ser_data = ~ser_data;
      @(negedge clk);
   endtask

   task automatic send_frame(input int code, input bit glitch);
      int          n;
      bit          lj;
      logic [23:0] val;
      logic        ws;
      logic        b;
      n  = m_width(code);
      lj = m_lj(code);
      for (int half = 0; half < 2; half++) begin
         val = 24'($urandom);
         ws  = lj ? logic'(half == 1) : logic'(half == 0);
         for (int k = 0; k < 32; k++) begin
            b = 1'($urandom);
            if (lj && k >= 1 && k <= n) b = val[24-k];
            if (!lj && k >= 32 - n)     b = val[23-(k-(32-n))];
            send_bit(ws, b, glitch);
         end
      end
   endtask

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_done && !finished) begin
         n_cmp++;
         if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            if (smp_valid !== 1'b1) begin
               n_fail++;
               $display("FAIL R8 strobe at cycle %0d: got %b expected 1", cyc, smp_valid);
            end else if (smp_left !== e.l || smp_right !== e.r) begin
               n_fail++;
               $display("FAIL %s (R7 alignment) data: got L=%h R=%h expected L=%h R=%h",
                        e.lj ? "R5" : "R3", smp_left, smp_right, e.l, e.r);
            end
            last_l  = e.l;
            last_r  = e.r;
            got_any = 1;
         end else begin
            if (smp_valid !== 1'b0) begin
               n_fail++;
               $display("FAIL R8/R9 strobe at cycle %0d: got %b expected 0", cyc, smp_valid);
            end
            if (smp_left !== last_l || smp_right !== last_r) begin
               n_fail++;
               $display("FAIL %s hold: got L=%h R=%h expected L=%h R=%h",
                        got_any ? "R11" : "R10", smp_left, smp_right, last_l, last_r);
            end
         end
      end
   end

   // watchdog
   always @(negedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1;
         n_fail++;
         $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      rst_done = 1;
      repeat (4) @(negedge clk);

      // R10 reset state explicitly
      n_cmp++;
      if (smp_valid !== 1'b0 || smp_left !== '0 || smp_right !== '0) begin
         n_fail++;
         $display("FAIL R10 reset: got V=%b L=%h R=%h expected 0 0 0", smp_valid, smp_left, smp_right);
      end

      // R3 R4 R7 R9: right-justified 16 bit, first frame dropped after reset
      for (int f = 0; f < 4; f++) send_frame(0, 0);
      // R1: glitching data while bit clock is high
      for (int f = 0; f < 2; f++) send_frame(0, 1);
      // R2 R9: format changes inside the right-justified family
      fmt_sel = 3'd1; for (int f = 0; f < 3; f++) send_frame(1, 0);
      fmt_sel = 3'd2; for (int f = 0; f < 3; f++) send_frame(2, 1);
      fmt_sel = 3'd6; for (int f = 0; f < 3; f++) send_frame(6, 0);
      fmt_sel = 3'd7; for (int f = 0; f < 3; f++) send_frame(7, 0);
      // R5 R6 R9: switch across families to left-justified
      fmt_sel = 3'd3; for (int f = 0; f < 4; f++) send_frame(3, 0);
      fmt_sel = 3'd4; for (int f = 0; f < 3; f++) send_frame(4, 1);
      fmt_sel = 3'd5; for (int f = 0; f < 3; f++) send_frame(5, 0);
      // R9: back to right-justified
      fmt_sel = 3'd0; for (int f = 0; f < 3; f++) send_frame(0, 0);
      send_bit(1'b1, 1'b0, 0);
      repeat (20) @(negedge clk);

      n_cmp++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R8 pending strobes: got %0d left expected 0", exp_q.size());
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule